// File: doc/BRIEF.md
# Complementary PWM Channel with Dead Band and Fault Forcing

This block is a single pulse-width channel for driving one leg of a power bridge. A free-running up-counter sets the period. One duty comparison yields a reference level, and that level becomes two complementary drive signals: a high-side drive and a low-side drive. Each drive turns on only after a programmable number of clock cycles of dead band, so the two switches of a leg never conduct at once. Each drive has its own polarity. Period, duty and dead-band values are written to shadow registers, and the live copies only change when the counter wraps. A waveform already in progress is therefore never cut short or stretched.

Two mechanisms can take control of the drives away from the modulator. A software override can set fixed drive levels, either at once or at the next wrap. Six fault lines have higher priority. Any active line takes over both drives combinationally, in the same cycle. Each drive can be configured to go low, go high or be released (output enable dropped). A fault is latched. It only ends when software writes the clear register after every fault line has gone inactive.

Register writes use a simple one-cycle strobe with an address and data. Register map (3-bit address):

- 0: period
- 1: duty
- 2: dead band, with the high-side delay in bits [DT_W-1:0] and the low-side delay in bits [2*DT_W-1:DT_W]
- 3: control, with run in bit 0, high-side invert in bit 1, low-side invert in bit 2, high-side fault level in [4:3] and low-side fault level in [6:5]
- 4: override, with enable in bit 0, sync in bit 1, high-side value in bit 2 and low-side value in bit 3
- 5: fault clear (the data is ignored)

Addresses 6 and 7 do nothing.

Two state machines set the behaviour.

The dead-band machine has five states:
- IDLE: stopped, both drives off.
- WAIT_HI: dead band before the high side.
- HI_ON: high side on.
- WAIT_LO: dead band before the low side.
- LO_ON: low side on.

Its transitions are:
- STOP: any state goes to IDLE when run is 0.
- RISE: the reference is high, so the machine goes to WAIT_HI, or straight to HI_ON if the high-side delay is zero.
- FALL: the reference is low, so the machine goes to WAIT_LO, or straight to LO_ON if the low-side delay is zero.
- EXPIRE: a wait state has run for its full delay, so the matching ON state begins.
- ABORT: the reference reverses while the machine is in a wait state, so it enters the opposite wait and restarts the timer.

The fault machine has two states, NORMAL and TRIPPED. TRIP moves it to TRIPPED when any fault line is high. RECOVER moves it back to NORMAL on a clear write made while all lines are low.

Top module: `cpwm_channel`

## Requirements
- R1: The counter runs 0,1,…,P-1 and wraps, where P is the live period. A period of 0 or 1 holds the counter at 0 and wraps it every cycle.
- R2: The reference is high in counter cycles with count < D, where D is the live duty. With zero dead band, the high-side drive is active in the cycle after each high-reference cycle. A duty of P or more keeps it active.
- R3: With zero dead band, the low-side drive is active in the cycle after each low-reference cycle while running. A duty of 0 keeps it active.
- R4: The high side becomes active only once the reference has been high for (high-side delay + 1) consecutive cycles. It drops in the cycle after the reference falls. The two drives are never active together.
- R5: The low side behaves the same way for a low reference, using the low-side delay.
- R6: If a dead band is at least as long as the matching reference pulse, that drive stays inactive for the whole period.
- R7: Writes to period, duty and dead band change only the shadow copies. These are copied to the live registers at each wrap, and in every cycle while stopped.
- R8: An invert bit set in control makes the matching drive active-low. The output enable stays 1.
- R9: When run is 0, both drives are inactive, so each output equals its invert bit. This includes the state after reset, where all registers are 0.
- R10: Any high fault line forces both drives in the same cycle, with no clock edge needed.
- R11: Fault level 0 drives 0 with the enable at 1. Level 1 drives 1 with the enable at 1. Levels 2 and 3 drive 0 with the enable at 0. Invert bits do not apply to forced levels.
- R12: A fault stays latched after the lines fall. It clears on a write to address 5 only if all fault lines are low at that edge.
- R13: An override write with sync 0 takes effect in the next cycle. With sync 1 it takes effect after the next wrap (or at once while stopped). While enabled, each drive outputs its raw override value with the enable at 1.
- R14: A fault has priority over an override, and an override has priority over the modulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | DATA_W | Write data (16 by default) |
| fault_in | input | N_FAULT | Fault lines, active high (6 by default) |
| hi_out | output | 1 | High-side drive level |
| hi_oe | output | 1 | High-side output enable |
| lo_out | output | 1 | Low-side drive level |
| lo_oe | output | 1 | Low-side output enable |

## Verification
Drive results lag the counter cycle that caused them by one register. The dead-band machine adds its delay on top of that. A period, duty or dead-band write shows up only after the counter wraps. An immediate override appears one cycle after its write. Fault forcing appears within the same cycle as the fault line, and the latch shows its effect from the next edge. The bench changes inputs on the falling edge and compares all four outputs 1 ns later against a cycle model that it updates on each rising edge. This alignment applies the register delays exactly, while combinational fault effects are seen in the same cycle.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;

    // Register addresses
    localparam logic [2:0] A_PERIOD = 3'd0;
    localparam logic [2:0] A_DUTY   = 3'd1;
    localparam logic [2:0] A_DEAD   = 3'd2;
    localparam logic [2:0] A_CTRL   = 3'd3;
    localparam logic [2:0] A_OVR    = 3'd4;
    localparam logic [2:0] A_FCLR   = 3'd5;

    // Control register: run[0], hi_inv[1], lo_inv[2], hi_flt[4:3], lo_flt[6:5]
    typedef struct packed {
        logic [1:0] lo_flt;
        logic [1:0] hi_flt;
        logic       lo_inv;
        logic       hi_inv;
        logic       run;
    } ctrl_t;

    // Override register: en[0], sync[1], hi_val[2], lo_val[3]
    typedef struct packed {
        logic lo_val;
        logic hi_val;
        logic sync;
        logic en;
    } ovr_t;

    typedef enum logic [1:0] {
        FLT_DRIVE_LO    = 2'd0,
        FLT_DRIVE_HI    = 2'd1,
        FLT_RELEASE     = 2'd2,
        FLT_RELEASE_ALT = 2'd3
    } flt_lvl_e;

    typedef enum logic [2:0] {
        DB_IDLE    = 3'd0,
        DB_WAIT_HI = 3'd1,
        DB_HI_ON   = 3'd2,
        DB_WAIT_LO = 3'd3,
        DB_LO_ON   = 3'd4
    } db_state_e;

    typedef enum logic {
        FS_NORMAL  = 1'b0,
        FS_TRIPPED = 1'b1
    } flt_state_e;

endpackage

// File: rtl/cpwm_regs.sv
module cpwm_regs
    import cpwm_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DT_W   = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [CNT_W-1:0]  sh_period,
    output logic [CNT_W-1:0]  sh_duty,
    output logic [DT_W-1:0]   sh_dt_hi,
    output logic [DT_W-1:0]   sh_dt_lo,
    output ctrl_t             ctrl,
    output logic              ovr_wr,
    output ovr_t              ovr_data,
    output logic              fclr_wr
);
    localparam int CTRL_W = $bits(ctrl_t);
    localparam int OVR_W  = $bits(ovr_t);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_period <= '0;
            sh_duty   <= '0;
            sh_dt_hi  <= '0;
            sh_dt_lo  <= '0;
            ctrl      <= '0;
        end else if (wr_en) begin
            unique case (wr_addr)
                A_PERIOD: sh_period <= wr_data[CNT_W-1:0];
                A_DUTY:   sh_duty   <= wr_data[CNT_W-1:0];
                A_DEAD: begin
                    sh_dt_hi <= wr_data[DT_W-1:0];
                    sh_dt_lo <= wr_data[2*DT_W-1:DT_W];
                end
                A_CTRL:   ctrl <= ctrl_t'(wr_data[CTRL_W-1:0]);
                default:  ;
            endcase
        end
    end

    always_comb begin
        ovr_wr   = wr_en && (wr_addr == A_OVR);
        ovr_data = ovr_t'(wr_data[OVR_W-1:0]);
        fclr_wr  = wr_en && (wr_addr == A_FCLR);
    end

endmodule

// File: rtl/cpwm_timebase.sv
module cpwm_timebase #(
    parameter int CNT_W = 16,
    parameter int DT_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] sh_period,
    input  logic [CNT_W-1:0] sh_duty,
    input  logic [DT_W-1:0]  sh_dt_hi,
    input  logic [DT_W-1:0]  sh_dt_lo,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] act_period,
    output logic [DT_W-1:0]  act_dt_hi,
    output logic [DT_W-1:0]  act_dt_lo,
    output logic             load,
    output logic             ref_on
);
    logic [CNT_W-1:0] act_duty;
    logic             wrap;

    always_comb begin
        wrap   = run && ((act_period <= CNT_W'(1)) || (cnt >= act_period - CNT_W'(1)));
        load   = !run || wrap;
        ref_on = run && (cnt < act_duty);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    // Shadow-to-live transfer at the period boundary or while stopped
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_period <= '0;
            act_duty   <= '0;
            act_dt_hi  <= '0;
            act_dt_lo  <= '0;
        end else if (load) begin
            act_period <= sh_period;
            act_duty   <= sh_duty;
            act_dt_hi  <= sh_dt_hi;
            act_dt_lo  <= sh_dt_lo;
        end
    end

endmodule

// File: rtl/cpwm_deadband.sv
module cpwm_deadband
    import cpwm_pkg::*;
#(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            ref_on,
    input  logic [DT_W-1:0] dt_hi,
    input  logic [DT_W-1:0] dt_lo,
    output logic            hi_act,
    output logic            lo_act
);
    db_state_e       state_q, state_d;
    db_state_e       enter_hi, enter_lo;
    logic [DT_W-1:0] tmr_q, tmr_d;

    always_comb begin
        enter_hi = (dt_hi == '0) ? DB_HI_ON : DB_WAIT_HI;
        enter_lo = (dt_lo == '0) ? DB_LO_ON : DB_WAIT_LO;
    end

    // Next-state: STOP, RISE, FALL, EXPIRE, ABORT
    always_comb begin
        state_d = state_q;
        tmr_d   = tmr_q;
        if (!run) begin
            state_d = DB_IDLE;
            tmr_d   = '0;
        end else begin
            unique case (state_q)
                DB_IDLE: begin
                    state_d = ref_on ? enter_hi : enter_lo;
                    tmr_d   = DT_W'(1);
                end
                DB_HI_ON: begin
                    if (!ref_on) begin
                        state_d = enter_lo;
                        tmr_d   = DT_W'(1);
                    end
                end
                DB_LO_ON: begin
                    if (ref_on) begin
                        state_d = enter_hi;
                        tmr_d   = DT_W'(1);
                    end
                end
                DB_WAIT_HI: begin
                    if (!ref_on) begin
                        state_d = enter_lo;
                        tmr_d   = DT_W'(1);
                    end else if (tmr_q >= dt_hi) begin
                        state_d = DB_HI_ON;
                    end else begin
                        tmr_d = tmr_q + DT_W'(1);
                    end
                end
                DB_WAIT_LO: begin
                    if (ref_on) begin
                        state_d = enter_hi;
                        tmr_d   = DT_W'(1);
                    end else if (tmr_q >= dt_lo) begin
                        state_d = DB_LO_ON;
                    end else begin
                        tmr_d = tmr_q + DT_W'(1);
                    end
                end
                default: begin
                    state_d = DB_IDLE;
                    tmr_d   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DB_IDLE;
            tmr_q   <= '0;
        end else begin
            state_q <= state_d;
            tmr_q   <= tmr_d;
        end
    end

    always_comb begin
        hi_act = (state_q == DB_HI_ON);
        lo_act = (state_q == DB_LO_ON);
    end

endmodule

// File: rtl/cpwm_outstage.sv
module cpwm_outstage
    import cpwm_pkg::*;
#(
    parameter int N_FAULT = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hi_act,
    input  logic               lo_act,
    input  logic               hi_inv,
    input  logic               lo_inv,
    input  logic [1:0]         hi_flt,
    input  logic [1:0]         lo_flt,
    input  logic               load,
    input  logic               ovr_wr,
    input  ovr_t               ovr_data,
    input  logic               fclr_wr,
    input  logic [N_FAULT-1:0] fault_in,
    output logic               tripped,
    output logic               hi_out,
    output logic               hi_oe,
    output logic               lo_out,
    output logic               lo_oe
);
    flt_state_e fs_q, fs_d;
    ovr_t       ovr_sh, ovr_act;
    logic       any_fault;
    logic       forcing;

    assign any_fault = |fault_in;

    // Fault latch: TRIP, RECOVER
    always_comb begin
        fs_d = fs_q;
        unique case (fs_q)
            FS_NORMAL:  if (any_fault) fs_d = FS_TRIPPED;
            FS_TRIPPED: if (!any_fault && fclr_wr) fs_d = FS_NORMAL;
            default:    fs_d = FS_TRIPPED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fs_q <= FS_NORMAL;
        else        fs_q <= fs_d;
    end

    assign tripped = (fs_q == FS_TRIPPED);
    assign forcing = tripped || any_fault;

    // Override: immediate writes bypass the shadow, synced ones wait for load
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovr_sh  <= '0;
            ovr_act <= '0;
        end else begin
            if (ovr_wr) ovr_sh <= ovr_data;
            if (ovr_wr && !ovr_data.sync) ovr_act <= ovr_data;
            else if (load)                ovr_act <= ovr_sh;
        end
    end

    logic [1:0] side_act, side_inv, side_ovr, side_o, side_oe;
    logic [1:0] side_flt [2];

    always_comb begin
        side_act    = {lo_act, hi_act};
        side_inv    = {lo_inv, hi_inv};
        side_ovr    = {ovr_act.lo_val, ovr_act.hi_val};
        side_flt[0] = hi_flt;
        side_flt[1] = lo_flt;
    end

    for (genvar s = 0; s < 2; s++) begin : g_side
        always_comb begin
            if (forcing) begin
                unique case (flt_lvl_e'(side_flt[s]))
                    FLT_DRIVE_LO: begin
                        side_o[s]  = 1'b0;
                        side_oe[s] = 1'b1;
                    end
                    FLT_DRIVE_HI: begin
                        side_o[s]  = 1'b1;
                        side_oe[s] = 1'b1;
                    end
                    FLT_RELEASE, FLT_RELEASE_ALT: begin
                        side_o[s]  = 1'b0;
                        side_oe[s] = 1'b0;
                    end
                    default: begin
                        side_o[s]  = 1'b0;
                        side_oe[s] = 1'b0;
                    end
                endcase
            end else if (ovr_act.en) begin
                side_o[s]  = side_ovr[s];
                side_oe[s] = 1'b1;
            end else begin
                side_o[s]  = side_act[s] ^ side_inv[s];
                side_oe[s] = 1'b1;
            end
        end
    end

    always_comb begin
        hi_out = side_o[0];
        hi_oe  = side_oe[0];
        lo_out = side_o[1];
        lo_oe  = side_oe[1];
    end

endmodule

// File: rtl/cpwm_channel.sv
module cpwm_channel
    import cpwm_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int DT_W    = 8,
    parameter int N_FAULT = 6,
    parameter int DATA_W  = (CNT_W > 2 * DT_W) ? CNT_W : 2 * DT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [2:0]         wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [N_FAULT-1:0] fault_in,
    output logic               hi_out,
    output logic               hi_oe,
    output logic               lo_out,
    output logic               lo_oe
);
    logic [CNT_W-1:0] sh_period, sh_duty, cnt, act_period;
    logic [DT_W-1:0]  sh_dt_hi, sh_dt_lo, act_dt_hi, act_dt_lo;
    ctrl_t            ctrl;
    ovr_t             ovr_data;
    logic             ovr_wr, fclr_wr, load, ref_on, hi_act, lo_act, tripped;

    cpwm_regs #(.CNT_W(CNT_W), .DT_W(DT_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .sh_period(sh_period), .sh_duty(sh_duty), .sh_dt_hi(sh_dt_hi), .sh_dt_lo(sh_dt_lo),
        .ctrl(ctrl), .ovr_wr(ovr_wr), .ovr_data(ovr_data), .fclr_wr(fclr_wr)
    );

    cpwm_timebase #(.CNT_W(CNT_W), .DT_W(DT_W)) u_timebase (
        .clk(clk), .rst_n(rst_n), .run(ctrl.run),
        .sh_period(sh_period), .sh_duty(sh_duty), .sh_dt_hi(sh_dt_hi), .sh_dt_lo(sh_dt_lo),
        .cnt(cnt), .act_period(act_period), .act_dt_hi(act_dt_hi), .act_dt_lo(act_dt_lo),
        .load(load), .ref_on(ref_on)
    );

    cpwm_deadband #(.DT_W(DT_W)) u_deadband (
        .clk(clk), .rst_n(rst_n), .run(ctrl.run), .ref_on(ref_on),
        .dt_hi(act_dt_hi), .dt_lo(act_dt_lo), .hi_act(hi_act), .lo_act(lo_act)
    );

    cpwm_outstage #(.N_FAULT(N_FAULT)) u_outstage (
        .clk(clk), .rst_n(rst_n), .hi_act(hi_act), .lo_act(lo_act),
        .hi_inv(ctrl.hi_inv), .lo_inv(ctrl.lo_inv), .hi_flt(ctrl.hi_flt), .lo_flt(ctrl.lo_flt),
        .load(load), .ovr_wr(ovr_wr), .ovr_data(ovr_data), .fclr_wr(fclr_wr),
        .fault_in(fault_in), .tripped(tripped),
        .hi_out(hi_out), .hi_oe(hi_oe), .lo_out(lo_out), .lo_oe(lo_oe)
    );

endmodule

// File: rtl/cpwm_channel_chk.sv
module cpwm_channel_chk #(
    parameter int CNT_W   = 16,
    parameter int N_FAULT = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic               run,
    input logic [CNT_W-1:0]   cnt,
    input logic [CNT_W-1:0]   act_period,
    input logic               load,
    input logic               ref_on,
    input logic               hi_act,
    input logic               lo_act,
    input logic               tripped,
    input logic               fclr_wr,
    input logic [N_FAULT-1:0] fault_in,
    input logic [1:0]         hi_flt,
    input logic [1:0]         lo_flt,
    input logic               hi_out,
    input logic               hi_oe,
    input logic               lo_oe
);
    assert_cnt_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (run && act_period > CNT_W'(1)) |-> (cnt < act_period));

    assert_no_overlap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(hi_act && lo_act));

    assert_hi_after_ref_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hi_act) |-> $past(ref_on));

    assert_lo_after_nref_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lo_act) |-> $past(run && !ref_on));

    assert_live_period_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act_period) |-> $past(load));

    assert_stop_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (!hi_act && !lo_act));

    assert_release_now_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ((|fault_in) && hi_flt[1]) |-> !hi_oe);

    assert_drive_low_now_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((|fault_in) && hi_flt == 2'd0) |-> (hi_oe && !hi_out));

    assert_lo_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ((|fault_in) && lo_flt[1]) |-> !lo_oe);

    assert_trip_latch_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (|fault_in) |=> tripped);

    assert_trip_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (tripped && !fclr_wr) |=> tripped);

endmodule

bind cpwm_channel cpwm_channel_chk #(.CNT_W(CNT_W), .N_FAULT(N_FAULT)) u_chk (
    .clk(clk), .rst_n(rst_n), .run(ctrl.run), .cnt(cnt), .act_period(act_period),
    .load(load), .ref_on(ref_on), .hi_act(hi_act), .lo_act(lo_act), .tripped(tripped),
    .fclr_wr(fclr_wr), .fault_in(fault_in), .hi_flt(ctrl.hi_flt), .lo_flt(ctrl.lo_flt),
    .hi_out(hi_out), .hi_oe(hi_oe), .lo_oe(lo_oe)
);

// File: tb/test_cpwm_channel.sv
`timescale 1ns/1ps
module test_cpwm_channel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [5:0]  fault_in = '0;
    logic        hi_out, hi_oe, lo_out, lo_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    cpwm_channel i_cpwm_channel (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .fault_in(fault_in), .hi_out(hi_out), .hi_oe(hi_oe), .lo_out(lo_out), .lo_oe(lo_oe)
    );

    // Cycle model built from the requirements
    int m_sh_per = 0, m_sh_duty = 0, m_sh_dth = 0, m_sh_dtl = 0;
    int m_per = 0, m_duty = 0, m_dth = 0, m_dtl = 0, m_cnt = 0;
    int m_lh = 0, m_ll = 0;
    bit m_run = 0, m_hinv = 0, m_linv = 0, m_hi = 0, m_lo = 0, m_trip = 0;
    int m_hflt = 0, m_lflt = 0;
    logic [3:0] m_ovr_sh = '0, m_ovr = '0;

    always @(posedge clk) begin
        bit ref_b, wrap_b, load_b;
        if (!rst_n) begin
            m_sh_per = 0; m_sh_duty = 0; m_sh_dth = 0; m_sh_dtl = 0;
            m_per = 0; m_duty = 0; m_dth = 0; m_dtl = 0; m_cnt = 0;
            m_lh = 0; m_ll = 0; m_run = 0; m_hinv = 0; m_linv = 0;
            m_hi = 0; m_lo = 0; m_trip = 0; m_hflt = 0; m_lflt = 0;
            m_ovr_sh = '0; m_ovr = '0;
        end else begin
            ref_b  = m_run && (m_cnt < m_duty);
            wrap_b = m_run && ((m_per <= 1) || (m_cnt >= m_per - 1));
            load_b = !m_run || wrap_b;
            if (!m_run) begin
                m_lh = 0; m_ll = 0; m_hi = 0; m_lo = 0;
            end else if (ref_b) begin
                m_lh = m_lh + 1; m_ll = 0; m_lo = 0;
                m_hi = m_hi || (m_lh >= m_dth + 1);
            end else begin
                m_ll = m_ll + 1; m_lh = 0; m_hi = 0;
                m_lo = m_lo || (m_ll >= m_dtl + 1);
            end
            if (load_b) begin
                m_cnt = 0;
                m_per = m_sh_per; m_duty = m_sh_duty; m_dth = m_sh_dth; m_dtl = m_sh_dtl;
                m_ovr = m_ovr_sh;
            end else begin
                m_cnt = m_cnt + 1;
            end
            if (fault_in != 0) m_trip = 1;
            else if (wr_en && wr_addr == 3'd5) m_trip = 0;
            if (wr_en) begin
                case (wr_addr)
                    3'd0: m_sh_per  = int'(wr_data);
                    3'd1: m_sh_duty = int'(wr_data);
                    3'd2: begin m_sh_dth = int'(wr_data[7:0]); m_sh_dtl = int'(wr_data[15:8]); end
                    3'd3: begin
                        m_run = wr_data[0]; m_hinv = wr_data[1]; m_linv = wr_data[2];
                        m_hflt = int'(wr_data[4:3]); m_lflt = int'(wr_data[6:5]);
                    end
                    3'd4: begin
                        m_ovr_sh = wr_data[3:0];
                        if (!wr_data[1]) m_ovr = wr_data[3:0];
                    end
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [1:0] exp_side(bit lo_side);
        int  lvl;
        bit  act, inv, ov;
        lvl = lo_side ? m_lflt : m_hflt;
        act = lo_side ? m_lo : m_hi;
        inv = lo_side ? m_linv : m_hinv;
        ov  = lo_side ? m_ovr[3] : m_ovr[2];
        if (m_trip || fault_in != 0) begin
            if (lvl == 0)      return 2'b01;
            else if (lvl == 1) return 2'b11;
            else               return 2'b00;
        end
        if (m_ovr[0]) return {ov, 1'b1};
        return {act ^ inv, 1'b1};
    endfunction

    task automatic check_pair(string tag, string nm, logic a_o, logic a_oe, logic [1:0] e);
        checks++;
        if (a_o !== e[1] || a_oe !== e[0]) begin
            errors++;
            $display("FAIL %s %s actual out=%b oe=%b expected out=%b oe=%b at %0t",
                     tag, nm, a_o, a_oe, e[1], e[0], $time);
        end
    endtask

    task automatic cmp(string th, string tl);
        check_pair(th, "high side", hi_out, hi_oe, exp_side(1'b0));
        check_pair(tl, "low side", lo_out, lo_oe, exp_side(1'b1));
    endtask

    task automatic step(bit en, logic [2:0] a, logic [15:0] d, logic [5:0] f,
                        string th, string tl);
        @(negedge clk);
        wr_en = en; wr_addr = a; wr_data = d; fault_in = f;
        #1;
        cmp(th, tl);
    endtask

    task automatic idle(int n, logic [5:0] f, string th, string tl);
        for (int i = 0; i < n; i++) step(1'b0, 3'd0, 16'd0, f, th, tl);
    endtask

    task automatic wr(logic [2:0] a, logic [15:0] d, string th, string tl);
        step(1'b1, a, d, fault_in, th, tl);
    endtask

    task automatic expect_bit(string tag, string nm, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", tag, nm, act, exp, $time);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog run actual=hung expected=complete");
            finish_up();
        end
    end

    initial begin
        int hi_cnt;
        int flt_hold;
        logic [5:0] flt_val;
        int unsigned r;
        void'($urandom(32'd4242));

        // R9: reset state, all registers zero, not running
        repeat (3) @(negedge clk);
        expect_bit("R9", "reset hi_out", hi_out, 1'b0);
        expect_bit("R9", "reset hi_oe", hi_oe, 1'b1);
        expect_bit("R9", "reset lo_out", lo_out, 1'b0);
        expect_bit("R9", "reset lo_oe", lo_oe, 1'b1);
        rst_n = 1'b1;
        idle(2, 6'd0, "R9", "R9");

        // R2 R3: plain complementary output, no dead band
        wr(3'd0, 16'd10, "R2", "R3");
        wr(3'd1, 16'd4, "R2", "R3");
        wr(3'd3, 16'd1, "R2", "R3");
        idle(30, 6'd0, "R2", "R3");
        wr(3'd1, 16'd12, "R2", "R3");
        idle(25, 6'd0, "R2", "R3");
        wr(3'd1, 16'd0, "R2", "R3");
        idle(25, 6'd0, "R2", "R3");

        // R4 R5: dead band 3 before high, 2 before low
        wr(3'd1, 16'd5, "R4", "R5");
        wr(3'd2, 16'h0203, "R4", "R5");
        idle(40, 6'd0, "R4", "R5");

        // R6: high-side delay longer than the pulse
        wr(3'd2, 16'h0107, "R6", "R5");
        wr(3'd1, 16'd4, "R6", "R5");
        idle(22, 6'd0, "R6", "R5");
        hi_cnt = 0;
        for (int i = 0; i < 30; i++) begin
            step(1'b0, 3'd0, 16'd0, 6'd0, "R6", "R5");
            if (hi_out) hi_cnt++;
        end
        expect_bit("R6", "high side never active", hi_cnt == 0, 1'b1);

        // R7: mid-period writes wait for the wrap
        wr(3'd2, 16'h0000, "R7", "R7");
        idle(13, 6'd0, "R7", "R7");
        wr(3'd0, 16'd6, "R7", "R7");
        idle(3, 6'd0, "R7", "R7");
        wr(3'd1, 16'd2, "R7", "R7");
        idle(20, 6'd0, "R7", "R7");

        // R1: degenerate periods
        wr(3'd0, 16'd1, "R1", "R1");
        wr(3'd1, 16'd1, "R1", "R1");
        idle(15, 6'd0, "R1", "R1");
        wr(3'd0, 16'd0, "R1", "R1");
        wr(3'd1, 16'd0, "R1", "R1");
        idle(15, 6'd0, "R1", "R1");
        wr(3'd0, 16'd2, "R1", "R1");
        wr(3'd1, 16'd1, "R1", "R1");
        idle(15, 6'd0, "R1", "R1");

        // R8: inverted polarity
        wr(3'd0, 16'd8, "R8", "R8");
        wr(3'd1, 16'd3, "R8", "R8");
        wr(3'd3, 16'd7, "R8", "R8");
        idle(30, 6'd0, "R8", "R8");

        // R9: stop
        wr(3'd3, 16'd6, "R9", "R9");
        idle(10, 6'd0, "R9", "R9");
        wr(3'd3, 16'd1, "R9", "R9");
        idle(10, 6'd0, "R9", "R9");

        // R10 R11 R12: faults, high released, low driven high
        wr(3'd3, 16'd49, "R11", "R11");
        idle(4, 6'b000100, "R10", "R10");
        expect_bit("R11", "released hi_oe", hi_oe, 1'b0);
        expect_bit("R11", "forced lo_out", lo_out, 1'b1);
        idle(5, 6'd0, "R12", "R12");
        step(1'b1, 3'd5, 16'd0, 6'b100000, "R12", "R12");
        idle(3, 6'd0, "R12", "R12");
        expect_bit("R12", "still tripped hi_oe", hi_oe, 1'b0);
        step(1'b1, 3'd5, 16'd0, 6'd0, "R12", "R12");
        idle(12, 6'd0, "R12", "R12");
        wr(3'd3, 16'd65, "R11", "R11");
        idle(3, 6'b000001, "R11", "R11");
        wr(3'd3, 16'd9, "R11", "R11");
        idle(3, 6'b010000, "R11", "R11");
        step(1'b1, 3'd5, 16'd0, 6'd0, "R12", "R12");
        idle(6, 6'd0, "R12", "R12");

        // R13: override immediate then synchronised
        wr(3'd4, 16'b0101, "R13", "R13");
        idle(8, 6'd0, "R13", "R13");
        wr(3'd4, 16'b1011, "R13", "R13");
        idle(12, 6'd0, "R13", "R13");
        // R14: fault over override
        idle(3, 6'b000010, "R14", "R14");
        step(1'b1, 3'd5, 16'd0, 6'd0, "R14", "R14");
        idle(3, 6'd0, "R14", "R14");
        wr(3'd4, 16'b0000, "R13", "R13");
        idle(5, 6'd0, "R13", "R13");

        // Randomised mix
        flt_hold = 0;
        flt_val  = '0;
        wr(3'd3, 16'd1, "R4", "R5");
        for (int i = 0; i < 5000; i++) begin
            logic        en;
            logic [2:0]  a;
            logic [15:0] d;
            en = 1'b1; a = 3'd0; d = '0;
            r = $urandom % 100;
            if (r < 6)       begin a = 3'd0; d = 16'($urandom % 18); end
            else if (r < 12) begin a = 3'd1; d = 16'($urandom % 20); end
            else if (r < 16) begin a = 3'd2; d = {8'($urandom % 5), 8'($urandom % 5)}; end
            else if (r < 18) begin a = 3'd3; d = {9'd0, 6'($urandom % 64), 1'(($urandom % 10) != 0)}; end
            else if (r < 20) begin a = 3'd4; d = {12'd0, 3'($urandom % 8), 1'(($urandom % 3) == 0)}; end
            else if (r < 22) begin a = 3'd5; end
            else if (r < 23) begin a = 3'($urandom % 2 + 6); d = 16'($urandom); end
            else en = 1'b0;
            if (flt_hold > 0) flt_hold--;
            else if ($urandom % 150 == 0) begin
                flt_hold = int'($urandom % 3) + 1;
                flt_val  = 6'(1 << ($urandom % 6));
            end
            step(en, a, d, (flt_hold > 0) ? flt_val : 6'd0, "R4", "R5");
        end
        idle(2, 6'd0, "R4", "R5");
        finish_up();
    end
endmodule